// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one memory-bus burst command into the string of byte addresses that the data path must visit, one address per beat. A command carries a start address, an 8-bit length field, a 3-bit size field and a 2-bit burst type. The block hands out each beat's byte address and its bus-word address, together with a flag that marks the final beat. A memory controller or slave front end consumes the beats at its own pace.

Both sides use valid/ready handshakes. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from the accepting edge until the edge that consumes the last beat. A beat transfers on an edge where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low the beat outputs hold their values, so the consumer can stall for any number of cycles. The beat outputs come straight from registers: the first beat appears one cycle after the command is accepted.

A command is checked as it is accepted. It is illegal when its beat size exceeds the bus width, when it uses the reserved burst code, when it is an incrementing burst that runs past a 4096-byte page, or when it is a wrapping burst whose beat count is not 2, 4, 8 or 16. An illegal command gives one beat flagged as an error in place of its burst.

Top module: `axi_burst_addr_gen`

## Requirements
- R1: After reset `beat_valid` is 0 and `cmd_ready` is 1.
- R2: `cmd_ready` is 0 from the accepting edge until the edge that takes the last beat, and rises in the cycle after that edge. A `cmd_valid` raised while a burst is in progress changes nothing in that burst.
- R3: A legal command's first beat address is the start address rounded down to a multiple of the beat size. The beat size is 2 to the power of the size field, in bytes.
- R4: Burst type 0 (fixed) presents the same address on every beat.
- R5: Burst type 1 (incrementing) adds the beat size to the address after each beat.
- R6: Burst type 2 (wrapping) adds the beat size after each beat. The burst's window starts at the start address rounded down to the total transfer size, which is the beat size times the beat count. When the address reaches the top of that window it returns to the bottom.
- R7: A legal command produces length+1 beats. `beat_last` is 1 exactly on beat number length, counting from 0, and `beat_valid` falls after that beat is taken.
- R8: `beat_word_addr` is `beat_addr` rounded down to a multiple of the bus width in bytes.
- R9: A size field whose beat size is larger than the bus width in bytes makes the command illegal.
- R10: An incrementing burst is illegal when the bytes from its aligned start address up to the next 4096-byte page boundary are fewer than its transfer size. A burst that ends exactly on the boundary is legal.
- R11: Burst type 3 is illegal. A wrapping burst is illegal unless its length field is 1, 3, 7 or 15.
- R12: An illegal command produces exactly one beat. On that beat `beat_err` and `beat_last` are 1 and `beat_addr` is the unmodified start address. Legal beats have `beat_err` at 0.
- R13: While `beat_valid` is 1 and `beat_ready` is 0, `beat_valid`, `beat_addr`, `beat_word_addr`, `beat_last` and `beat_err` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | 8 | Beat count minus one |
| cmd_size | input | 3 | Log2 of the beat size in bytes |
| cmd_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 reserved |
| beat_valid | output | 1 | A beat address is presented |
| beat_ready | input | 1 | Consumer takes the beat (advance strobe) |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_word_addr | output | ADDR_W | Bus-word aligned address of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| beat_err | output | 1 | Command was illegal |

## Verification
The bench targets the wrap point. A wrapping burst that starts in the middle of its window has to fall back to the window base; a design that computed the window from the aligned address with the wrong span, or never wrapped, would run past the window. Incrementing bursts are placed to end exactly on a 4096-byte boundary and also one beat past it, which catches an off-by-one in the page check that would reject a legal burst or accept an illegal one. Unaligned start addresses, oversize beats, the reserved burst code and wrapping lengths that are not powers of two are mixed into random traffic. Random consumer stalls and commands poked in the middle of a burst would expose outputs that move under back-pressure or a command taken too early.

// File: rtl/axbg_pkg.sv
package axbg_pkg;

  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2,
    BURST_RSVD  = 2'd3
  } burst_e;

  localparam int LEN_W      = 8;
  localparam int SIZE_W     = 3;
  localparam int PAGE_LG    = 12;
  localparam int XFER_W     = 16;
  localparam int WRAP_MAXLG = 4;

endpackage

// File: rtl/axbg_cmd_check.sv
module axbg_cmd_check
  import axbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  burst_e            burst,
  output logic              illegal,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] wrap_mask
);

  localparam int BUS_LG = $clog2(BUS_BYTES);

  logic [XFER_W-1:0] beats;
  logic [XFER_W-1:0] xfer_bytes;
  logic [XFER_W-1:0] page_left;
  logic [WRAP_MAXLG:1] wrap_len_hit;
  logic size_bad, page_bad, wrap_bad, type_bad;

  // One comparator per legal wrapping beat count (2, 4, 8, 16).
  for (genvar g = 1; g <= WRAP_MAXLG; g++) begin : g_wrap_len
    assign wrap_len_hit[g] = (len == LEN_W'((1 << g) - 1));
  end

  always_comb begin
    step       = ADDR_W'(1) << size;
    first_addr = addr & ~(step - ADDR_W'(1));
    beats      = XFER_W'(len) + XFER_W'(1);
    xfer_bytes = beats << size;
    page_left  = XFER_W'(1 << PAGE_LG) - XFER_W'(first_addr[PAGE_LG-1:0]);
    wrap_mask  = ADDR_W'(xfer_bytes) - ADDR_W'(1);

    size_bad = (int'(size) > BUS_LG);
    type_bad = (burst == BURST_RSVD);
    page_bad = (burst == BURST_INCR) && (page_left < xfer_bytes);
    wrap_bad = (burst == BURST_WRAP) && !(|wrap_len_hit);
    illegal  = size_bad | type_bad | page_bad | wrap_bad;
  end

endmodule

// File: rtl/axbg_addr_step.sv
module axbg_addr_step
  import axbg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] step,
  input  logic [ADDR_W-1:0] wrap_mask,
  input  burst_e            burst,
  output logic [ADDR_W-1:0] next
);

  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum = cur + step;
    unique case (burst)
      BURST_FIXED: next = cur;
      // Window base bits are kept; only the offset inside the window moves,
      // so passing the top of the window lands on its base.
      BURST_WRAP:  next = (cur & ~wrap_mask) | (sum & wrap_mask);
      default:     next = sum;
    endcase
  end

endmodule

// File: rtl/axbg_beat_seq.sv
module axbg_beat_seq
  import axbg_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  burst_e            cmd_burst,
  input  logic              chk_illegal,
  input  logic [ADDR_W-1:0] chk_first,
  input  logic [ADDR_W-1:0] chk_step,
  input  logic [ADDR_W-1:0] chk_mask,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  output logic              beat_err
);

  logic              busy_q;
  logic [ADDR_W-1:0] cur_q, step_q, mask_q, next_addr;
  logic [LEN_W-1:0]  len_q, idx_q;
  burst_e            burst_q;
  logic              err_q;
  logic              accept, fire;

  axbg_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .cur       (cur_q),
    .step      (step_q),
    .wrap_mask (mask_q),
    .burst     (burst_q),
    .next      (next_addr)
  );

  assign cmd_ready  = !busy_q;
  assign accept     = cmd_valid && !busy_q;
  assign beat_valid = busy_q;
  assign fire       = busy_q && beat_ready;
  assign beat_addr  = cur_q;
  assign beat_err   = err_q;
  assign beat_last  = err_q || (idx_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      step_q  <= '0;
      mask_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      burst_q <= BURST_FIXED;
      err_q   <= 1'b0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      cur_q   <= chk_illegal ? cmd_addr : chk_first;
      step_q  <= chk_step;
      mask_q  <= chk_mask;
      len_q   <= cmd_len;
      idx_q   <= '0;
      burst_q <= cmd_burst;
      err_q   <= chk_illegal;
    end else if (fire) begin
      if (beat_last) begin
        busy_q <= 1'b0;
      end else begin
        cur_q <= next_addr;
        idx_q <= idx_q + LEN_W'(1);
      end
    end
  end

  // R13: outputs frozen under back-pressure
  p_hold_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)
                                     && $stable(beat_last) && $stable(beat_err)));

  // R7: burst ends right after its last beat is taken
  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && beat_last) |=> !beat_valid);

  // R7: a non-final beat is followed by another beat
  p_more_beats_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last) |=> beat_valid);

  // R12: an error command yields a single beat
  p_err_one_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && beat_err) |=> !beat_valid);

  // R4: fixed bursts never move
  p_fixed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last && burst_q == BURST_FIXED) |=> $stable(beat_addr));

  // R5: incrementing bursts step by the beat size
  p_incr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last && burst_q == BURST_INCR)
      |=> (beat_addr == $past(beat_addr) + $past(step_q)));

  // R6: wrapping bursts stay inside their window
  p_wrap_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !beat_last && burst_q == BURST_WRAP)
      |=> ((beat_addr & ~mask_q) == $past(beat_addr & ~mask_q)));

  // R2: a command is never taken while beats are pending
  p_no_take_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(fire && beat_last)) |=> busy_q && $stable(len_q));

endmodule

// File: rtl/axi_burst_addr_gen.sv
module axi_burst_addr_gen
  import axbg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUS_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_len,
  input  logic [2:0]        cmd_size,
  input  logic [1:0]        cmd_burst,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [ADDR_W-1:0] beat_word_addr,
  output logic              beat_last,
  output logic              beat_err
);

  localparam logic [ADDR_W-1:0] WORD_MASK = ADDR_W'(BUS_BYTES - 1);
  localparam int                BUS_LG    = $clog2(BUS_BYTES);

  burst_e            burst_in;
  logic              chk_illegal;
  logic [ADDR_W-1:0] chk_first, chk_step, chk_mask;

  assign burst_in = burst_e'(cmd_burst);

  axbg_cmd_check #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_check (
    .addr       (cmd_addr),
    .len        (cmd_len),
    .size       (cmd_size),
    .burst      (burst_in),
    .illegal    (chk_illegal),
    .first_addr (chk_first),
    .step       (chk_step),
    .wrap_mask  (chk_mask)
  );

  axbg_beat_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_addr    (cmd_addr),
    .cmd_len     (cmd_len),
    .cmd_burst   (burst_in),
    .chk_illegal (chk_illegal),
    .chk_first   (chk_first),
    .chk_step    (chk_step),
    .chk_mask    (chk_mask),
    .beat_valid  (beat_valid),
    .beat_ready  (beat_ready),
    .beat_addr   (beat_addr),
    .beat_last   (beat_last),
    .beat_err    (beat_err)
  );

  assign beat_word_addr = beat_addr & ~WORD_MASK;

  // R9: an oversize beat always surfaces as an error beat
  p_size_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && int'(cmd_size) > BUS_LG) |=> (beat_valid && beat_err));

  // R11: the reserved burst code always surfaces as an error beat
  p_rsvd_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_burst == 2'd3) |=> (beat_valid && beat_err));

  // R8: word address carries no sub-word bits
  p_word_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> ((beat_word_addr & WORD_MASK) == '0));

  // R2: command side closed while a burst is open
  p_ready_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !cmd_ready);

endmodule

// File: tb/axi_burst_addr_gen_tb.sv
`timescale 1ns/1ps
module axi_burst_addr_gen_tb;

  localparam int AW = 32;
  localparam int DB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_len = '0;
  logic [2:0]    cmd_size = '0;
  logic [1:0]    cmd_burst = '0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [AW-1:0] beat_word_addr;
  logic          beat_last;
  logic          beat_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  axi_burst_addr_gen #(.ADDR_W(AW), .BUS_BYTES(DB)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size), .cmd_burst(cmd_burst),
    .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_word_addr(beat_word_addr),
    .beat_last(beat_last), .beat_err(beat_err)
  );

  task automatic check(string req, longint unsigned act, longint unsigned exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(longint unsigned a, int len, int size, int burst);
    longint unsigned nb, ts, al;
    if (size > 3) return 1'b1;
    if (burst == 3) return 1'b1;
    nb = longint'(1) << size;
    ts = nb * (len + 1);
    al = (a / nb) * nb;
    if (burst == 1 && (4096 - (al % 4096)) < ts) return 1'b1;
    if (burst == 2 && !(len == 1 || len == 3 || len == 7 || len == 15)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic longint unsigned exp_addr(longint unsigned a, int len, int size,
                                               int burst, int n);
    longint unsigned nb, ts, cur, lo, hi;
    if (exp_err(a, len, size, burst)) return a;
    nb  = longint'(1) << size;
    ts  = nb * (len + 1);
    cur = (a / nb) * nb;
    lo  = (a / ts) * ts;
    hi  = lo + ts;
    for (int i = 0; i < n; i++) begin
      if (burst != 0) cur = cur + nb;
      if (burst == 2 && cur == hi) cur = lo;
    end
    return cur;
  endfunction

  task automatic run_cmd(longint unsigned a, int len, int size, int burst, bit poke);
    bit e;
    int nexp;
    longint unsigned ea;
    logic [AW-1:0] held;
    e    = exp_err(a, len, size, burst);
    nexp = e ? 1 : len + 1;
    check("R2 ready before command", cmd_ready, 1);
    cmd_valid = 1'b1;
    cmd_addr  = AW'(a);
    cmd_len   = 8'(len);
    cmd_size  = 3'(size);
    cmd_burst = 2'(burst);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr  = $urandom;
    cmd_len   = 8'($urandom);
    cmd_burst = 2'($urandom);
    for (int n = 0; n < nexp; n++) begin
      if ($urandom % 4 == 0) begin
        beat_ready = 1'b0;
        held = beat_addr;
        @(negedge clk);
        check("R13 valid held in stall", beat_valid, 1);
        check("R13 addr held in stall", beat_addr, held);
      end
      if (!beat_valid) begin
        check("R7 beat missing", 0, 1);
        break;
      end
      if (n == 0) check("R2 ready low in burst", cmd_ready, 0);
      if (poke && n == 0) cmd_valid = 1'b1;
      ea = exp_addr(a, len, size, burst, n);
      check(burst == 0 ? "R4 fixed addr" : burst == 1 ? "R5 incr addr" :
            burst == 2 ? "R6 wrap addr" : "R12 err addr", beat_addr, AW'(ea));
      if (n == 0 && !e) check("R3 first beat aligned", beat_addr, AW'(ea));
      check("R8 word addr", beat_word_addr, AW'((ea / DB) * DB));
      check("R7 last flag", beat_last, (n == nexp - 1));
      check(size > 3 ? "R9 size err" : burst == 3 ? "R11 type err" :
            burst == 1 ? "R10 page err" : "R12 err flag", beat_err, e);
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0;
      cmd_valid  = 1'b0;
    end
    check("R7 valid falls after last", beat_valid, 0);
    check("R2 ready after last", cmd_ready, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R1 reset valid", beat_valid, 0);
    check("R1 reset ready", cmd_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(32'h1003, 3, 2, 0, 1'b0);   // R4 fixed, R3 unaligned
    run_cmd(32'h1003, 4, 2, 1, 1'b1);   // R3 R5 unaligned incr, poke (R2)
    run_cmd(32'h0FC0, 7, 3, 1, 1'b0);   // R10 ends exactly at page
    run_cmd(32'h0FC8, 7, 3, 1, 1'b0);   // R10 one beat past page
    run_cmd(32'h1234, 3, 2, 2, 1'b0);   // R6 wrap mid window
    run_cmd(32'h2038, 15, 3, 2, 1'b1);  // R6 16 beats wrap
    run_cmd(32'h1234, 2, 2, 2, 1'b0);   // R11 bad wrap length
    run_cmd(32'h1000, 0, 4, 1, 1'b0);   // R9 oversize beat
    run_cmd(32'h1000, 3, 0, 3, 1'b0);   // R11 reserved type
    run_cmd(32'h0000, 255, 0, 1, 1'b0); // R7 longest burst
    run_cmd(32'hFFFF_FFF0, 0, 3, 0, 1'b0);

    for (int k = 0; k < 250; k++) begin
      int b, s, l;
      longint unsigned a;
      b = ($urandom % 8 < 7) ? $urandom % 3 : 3;
      s = ($urandom % 8 < 7) ? $urandom % 4 : $urandom % 8;
      if (b == 2) l = ($urandom % 6 == 0) ? $urandom % 16 : (1 << (1 + $urandom % 4)) - 1;
      else        l = ($urandom % 10 == 0) ? $urandom % 256 : $urandom % 24;
      a = $urandom;
      if ($urandom % 4 == 0) a = (a & 32'hFFFF_F000) | (32'h1000 - ((l + 1) << (s & 3)));
      run_cmd(a, l, s, b, ($urandom % 5 == 0));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule